// File: doc/BRIEF.md
# Two-Way Time-Transfer Minimum-Delay Offset Filter

This block turns the four timestamps of a two-way time exchange into a round-trip delay and a clock offset. The four times are the client's send time, the server's receive time, the server's send time and the client's receive time. Every exchange that yields a non-negative delay goes into a small sliding window of recent samples. The block always presents the offset of the window entry whose delay is lowest. A low-delay exchange has probably seen the least queuing and the most symmetric path, so its offset is the most trustworthy.

Each timestamp is a signed 64-bit fixed-point value with its own valid strobe. The first three timestamps are held in registers until the client-receive strobe arrives, and that strobe starts the computation. If all four strobes are high in the same cycle, one exchange completes per cycle. The filtered offset feeds a clock servo elsewhere in the design.

Top module: `tt_offset_filter`

## Requirements
- R1: A high `cli_tx_vld`, `srv_rx_vld` or `srv_tx_vld` loads its timestamp into a holding register that keeps its value until the next strobe on that input. When `cli_rx_vld` is high, the exchange uses the port value of each of the other three inputs whose strobe is also high in that cycle, and the held value of each whose strobe is low.
- R2: The round-trip delay of an exchange equals (client receive − client send) − (server send − server receive). It is reported on `best_dly` as an unsigned 65-bit value.
- R3: The offset equals ((server receive − client send) + (server send − client receive)) / 2, rounded toward minus infinity (for example, a sum of −3 gives −2 and a sum of 7 gives 3). It is reported on `best_ofs` as a 65-bit two's-complement value.
- R4: The window holds the DEPTH (default 8) most recent stored samples. When the window is full, a new sample replaces the oldest one.
- R5: `best_dly` and `best_ofs` belong to the stored sample with the lowest delay in the window.
- R6: A sample whose computed delay is negative is not stored. The outputs remain unchanged afterwards, and no window entry is evicted by it.
- R7: When several stored samples share the lowest delay, the most recently stored one is selected.
- R8: After a synchronous active-high reset, `best_vld`, `best_dly` and `best_ofs` are all zero. `best_vld` stays low until a first sample has been stored.
- R9: The outputs reflect an exchange from the third rising clock edge after the edge that sampled its `cli_rx_vld`. A new exchange is accepted on every cycle.
- R10: All differences are formed at full width, so timestamps at the extremes of the signed 64-bit range give exact results. Examples are a delay of 2^65−2 and offsets of ±(2^64−1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cli_tx_vld | input | 1 | Client send timestamp strobe |
| cli_tx | input | 64 | Client send timestamp, signed |
| srv_rx_vld | input | 1 | Server receive timestamp strobe |
| srv_rx | input | 64 | Server receive timestamp, signed |
| srv_tx_vld | input | 1 | Server send timestamp strobe |
| srv_tx | input | 64 | Server send timestamp, signed |
| cli_rx_vld | input | 1 | Client receive timestamp strobe; starts the computation |
| cli_rx | input | 64 | Client receive timestamp, signed |
| best_vld | output | 1 | At least one sample is stored |
| best_dly | output | 65 | Lowest stored delay, unsigned |
| best_ofs | output | 65 | Offset belonging to the lowest-delay entry, two's complement |

## Verification
Two things can happen in the same cycle. The first is a fresh client-send, server-receive or server-send strobe arriving together with the client-receive strobe, so that port values must win over held ones. The bench drives all four strobes together, then drives them one at a time, then sends client-receive alone while the idle ports carry unrelated values. The second is a new sample overwriting the window entry that currently holds the minimum, in the very cycle the search must move to the next-best entry. The bench fills the window, pushes samples until the minimum-delay entry is evicted, and compares the outputs against an independent window model. The expected values are also written out for the eviction point.

// File: rtl/tt_xfer_pkg.sv
package tt_xfer_pkg;

  localparam int TT_TS_W_DEF  = 64;
  localparam int TT_DEPTH_DEF = 8;

  // Pointer width for a window of the given depth (at least one bit).
  function automatic int tt_ptr_w(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

endpackage

// File: rtl/tt_diff_stage.sv
// Stage 1: four pairwise differences, each one bit wider than a timestamp.
module tt_diff_stage #(
  parameter int TS_W = 64
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_vld,
  input  logic signed [TS_W-1:0] t_a,   // client send
  input  logic signed [TS_W-1:0] t_b,   // server receive
  input  logic signed [TS_W-1:0] t_c,   // server send
  input  logic signed [TS_W-1:0] t_d,   // client receive
  output logic                   out_vld,
  output logic signed [TS_W:0]   d_loop,  // d - a
  output logic signed [TS_W:0]   d_turn,  // c - b
  output logic signed [TS_W:0]   d_fwd,   // b - a
  output logic signed [TS_W:0]   d_rev    // c - d
);

  localparam int DW = TS_W + 1;

  logic signed [DW-1:0] xa, xb, xc, xd;

  assign xa = {t_a[TS_W-1], t_a};
  assign xb = {t_b[TS_W-1], t_b};
  assign xc = {t_c[TS_W-1], t_c};
  assign xd = {t_d[TS_W-1], t_d};

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
    end else begin
      out_vld <= in_vld;
    end
    if (in_vld) begin
      d_loop <= xd - xa;
      d_turn <= xc - xb;
      d_fwd  <= xb - xa;
      d_rev  <= xc - xd;
    end
  end

endmodule

// File: rtl/tt_combine_stage.sv
// Stage 2: delay at full width, offset as a floor-halved sum.
module tt_combine_stage #(
  parameter int TS_W = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_vld,
  input  logic signed [TS_W:0] d_loop,
  input  logic signed [TS_W:0] d_turn,
  input  logic signed [TS_W:0] d_fwd,
  input  logic signed [TS_W:0] d_rev,
  output logic                 out_vld,
  output logic                 out_keep,
  output logic [TS_W:0]        out_dly,
  output logic [TS_W:0]        out_ofs
);

  localparam int DW = TS_W + 1;
  localparam int WW = TS_W + 2;

  logic signed [WW-1:0] rtt_w;
  logic signed [DW-1:0] half_fwd, half_rev;
  logic [DW-1:0]        ofs_c;

  assign rtt_w = {d_loop[DW-1], d_loop} - {d_turn[DW-1], d_turn};

  // floor((f + r) / 2) = floor(f/2) + floor(r/2) + (f & r & 1)
  assign half_fwd = d_fwd >>> 1;
  assign half_rev = d_rev >>> 1;
  assign ofs_c    = half_fwd + half_rev + {{(DW-1){1'b0}}, d_fwd[0] & d_rev[0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= 1'b0;
      out_keep <= 1'b0;
    end else begin
      out_vld  <= in_vld;
      out_keep <= in_vld & ~rtt_w[WW-1];
    end
    if (in_vld) begin
      out_dly <= rtt_w[DW-1:0];
      out_ofs <= ofs_c;
    end
  end

endmodule

// File: rtl/tt_min_window.sv
// Sliding window of recent samples with a newest-wins minimum search.
module tt_min_window #(
  parameter int DW    = 65,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_vld,
  input  logic          wr_keep,
  input  logic [DW-1:0] wr_dly,
  input  logic [DW-1:0] wr_ofs,
  output logic          best_vld,
  output logic [DW-1:0] best_dly,
  output logic [DW-1:0] best_ofs
);

  localparam int PTR_W = tt_xfer_pkg::tt_ptr_w(DEPTH);

  logic [DW-1:0]    ent_dly [DEPTH];
  logic [DW-1:0]    ent_ofs [DEPTH];
  logic [DEPTH-1:0] ent_vld;
  logic [PTR_W-1:0] wptr;     // slot of the oldest entry, next to be written

  logic             do_wr;
  logic             found;
  logic [DW-1:0]    sel_dly;
  logic [DW-1:0]    sel_ofs;

  assign do_wr = wr_vld & wr_keep;

  // Sample store: no reset on the data, only on the occupancy flags.
  always_ff @(posedge clk) begin
    if (do_wr) begin
      ent_dly[wptr] <= wr_dly;
      ent_ofs[wptr] <= wr_ofs;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_vld <= '0;
      wptr    <= '0;
    end else if (do_wr) begin
      ent_vld[wptr] <= 1'b1;
      if (wptr == PTR_W'(DEPTH - 1)) begin
        wptr <= '0;
      end else begin
        wptr <= wptr + 1'b1;
      end
    end
  end

  // Scan from oldest to newest; "<=" lets a newer equal delay take over.
  always_comb begin
    found   = 1'b0;
    sel_dly = '0;
    sel_ofs = '0;
    for (int i = 0; i < DEPTH; i++) begin
      int idx;
      idx = (int'(wptr) + i) % DEPTH;
      if (ent_vld[idx] && (!found || (ent_dly[idx] <= sel_dly))) begin
        found   = 1'b1;
        sel_dly = ent_dly[idx];
        sel_ofs = ent_ofs[idx];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      best_vld <= 1'b0;
      best_dly <= '0;
      best_ofs <= '0;
    end else begin
      best_vld <= found;
      best_dly <= sel_dly;
      best_ofs <= sel_ofs;
    end
  end

  // The chosen delay is not above any occupied entry.
  always_ff @(posedge clk) begin
    if (!rst && found) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (ent_vld[i]) begin
          AST_MIN_DELAY: assert (sel_dly <= ent_dly[i]); // R5
        end
      end
    end
  end

  AST_EMPTY_INVALID: assert property (@(posedge clk) disable iff (rst)
    (ent_vld == '0) |=> !best_vld); // R8

  AST_NEG_NOT_STORED: assert property (@(posedge clk) disable iff (rst)
    (wr_vld && !wr_keep) |=> ($stable(ent_vld) && $stable(wptr))); // R6

  AST_FILL_MONOTONIC: assert property (@(posedge clk) disable iff (rst)
    wr_vld |=> ($countones(ent_vld) >= $countones($past(ent_vld)))); // R4

endmodule

// File: rtl/tt_offset_filter.sv
module tt_offset_filter #(
  parameter int TS_W  = tt_xfer_pkg::TT_TS_W_DEF,
  parameter int DEPTH = tt_xfer_pkg::TT_DEPTH_DEF
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cli_tx_vld,
  input  logic signed [TS_W-1:0] cli_tx,
  input  logic                   srv_rx_vld,
  input  logic signed [TS_W-1:0] srv_rx,
  input  logic                   srv_tx_vld,
  input  logic signed [TS_W-1:0] srv_tx,
  input  logic                   cli_rx_vld,
  input  logic signed [TS_W-1:0] cli_rx,
  output logic                   best_vld,
  output logic [TS_W:0]          best_dly,
  output logic [TS_W:0]          best_ofs
);

  localparam int DW = TS_W + 1;

  logic signed [TS_W-1:0] hold_a, hold_b, hold_c;
  logic signed [TS_W-1:0] use_a, use_b, use_c;

  // R1: hold the first three timestamps until the closing one arrives.
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_a <= '0;
      hold_b <= '0;
      hold_c <= '0;
    end else begin
      if (cli_tx_vld) hold_a <= cli_tx;
      if (srv_rx_vld) hold_b <= srv_rx;
      if (srv_tx_vld) hold_c <= srv_tx;
    end
  end

  assign use_a = cli_tx_vld ? cli_tx : hold_a;
  assign use_b = srv_rx_vld ? srv_rx : hold_b;
  assign use_c = srv_tx_vld ? srv_tx : hold_c;

  logic                 s1_vld;
  logic signed [DW-1:0] s1_loop, s1_turn, s1_fwd, s1_rev;

  tt_diff_stage #(.TS_W(TS_W)) u_diff (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (cli_rx_vld),
    .t_a     (use_a),
    .t_b     (use_b),
    .t_c     (use_c),
    .t_d     (cli_rx),
    .out_vld (s1_vld),
    .d_loop  (s1_loop),
    .d_turn  (s1_turn),
    .d_fwd   (s1_fwd),
    .d_rev   (s1_rev)
  );

  logic          s2_vld, s2_keep;
  logic [DW-1:0] s2_dly, s2_ofs;

  tt_combine_stage #(.TS_W(TS_W)) u_comb (
    .clk      (clk),
    .rst      (rst),
    .in_vld   (s1_vld),
    .d_loop   (s1_loop),
    .d_turn   (s1_turn),
    .d_fwd    (s1_fwd),
    .d_rev    (s1_rev),
    .out_vld  (s2_vld),
    .out_keep (s2_keep),
    .out_dly  (s2_dly),
    .out_ofs  (s2_ofs)
  );

  tt_min_window #(.DW(DW), .DEPTH(DEPTH)) u_win (
    .clk      (clk),
    .rst      (rst),
    .wr_vld   (s2_vld),
    .wr_keep  (s2_keep),
    .wr_dly   (s2_dly),
    .wr_ofs   (s2_ofs),
    .best_vld (best_vld),
    .best_dly (best_dly),
    .best_ofs (best_ofs)
  );

endmodule

// File: tb/tt_offset_filter_bench.sv
module tt_offset_filter_bench;

  localparam logic signed [63:0] TMAX = 64'sh7FFF_FFFF_FFFF_FFFF;
  localparam logic signed [63:0] TMIN = 64'sh8000_0000_0000_0000;

  logic clk = 1'b0;
  logic rst;
  always #10 clk = ~clk;   // 50 MHz

  logic               a_v, b_v, c_v, d_v;
  logic signed [63:0] a_t, b_t, c_t, d_t;
  logic               best_vld;
  logic [64:0]        best_dly, best_ofs;

  tt_offset_filter u_tt_offset_filter (
    .clk(clk), .rst(rst),
    .cli_tx_vld(a_v), .cli_tx(a_t),
    .srv_rx_vld(b_v), .srv_rx(b_t),
    .srv_tx_vld(c_v), .srv_tx(c_t),
    .cli_rx_vld(d_v), .cli_rx(d_t),
    .best_vld(best_vld), .best_dly(best_dly), .best_ofs(best_ofs)
  );

  int checks = 0;
  int errors = 0;

  // Independent window model
  logic [64:0] m_dly [8];
  logic [64:0] m_ofs [8];
  logic        m_vld [8];
  int          m_ptr;

  function automatic void model_clear();
    for (int k = 0; k < 8; k++) m_vld[k] = 1'b0;
    m_ptr = 0;
  endfunction

  function automatic void model_push(input logic signed [63:0] a, b, c, d);
    logic signed [65:0] xa, xb, xc, xd, dl, sm, sh;
    xa = a; xb = b; xc = c; xd = d;
    dl = (xd - xa) - (xc - xb);
    sm = (xb - xa) + (xc - xd);
    sh = sm >>> 1;
    if (dl >= 0) begin
      m_dly[m_ptr] = dl[64:0];
      m_ofs[m_ptr] = sh[64:0];
      m_vld[m_ptr] = 1'b1;
      m_ptr = (m_ptr + 1) % 8;
    end
  endfunction

  task automatic chk(input string tag, input logic [64:0] act, input logic [64:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_model(input string tag);
    logic        v;
    logic [64:0] d, o;
    v = 1'b0; d = '0; o = '0;
    for (int k = 0; k < 8; k++) begin
      int ix;
      ix = (m_ptr + k) % 8;
      if (m_vld[ix] && (!v || m_dly[ix] <= d)) begin
        v = 1'b1; d = m_dly[ix]; o = m_ofs[ix];
      end
    end
    chk({tag, " vld"}, {64'd0, best_vld}, {64'd0, v});
    chk({tag, " dly"}, best_dly, d);
    chk({tag, " ofs"}, best_ofs, o);
  endtask

  task automatic idle_inputs();
    a_v = 0; b_v = 0; c_v = 0; d_v = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    idle_inputs();
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_clear();
  endtask

  // Drive a full exchange in one cycle; result checked 4 negedges later.
  task automatic exch(input string tag, input logic signed [63:0] a, b, c, d);
    @(negedge clk);
    a_v = 1; b_v = 1; c_v = 1; d_v = 1;
    a_t = a; b_t = b; c_t = c; d_t = d;
    @(negedge clk);
    idle_inputs();
    repeat (3) @(negedge clk);
    model_push(a, b, c, d);
    chk_model(tag);
  endtask

  task automatic t_reset_state();
    chk("R8 reset vld", {64'd0, best_vld}, 65'd0);
    chk("R8 reset dly", best_dly, 65'd0);
    chk("R8 reset ofs", best_ofs, 65'd0);
    repeat (4) @(negedge clk);
    chk("R8 idle stays invalid", {64'd0, best_vld}, 65'd0);
  endtask

  task automatic t_basic_latency();
    @(negedge clk);
    a_v = 1; b_v = 1; c_v = 1; d_v = 1;
    a_t = 100; b_t = 150; c_t = 160; d_t = 220;
    @(negedge clk);
    idle_inputs();
    @(negedge clk);
    @(negedge clk);
    chk("R9 not before third edge", {64'd0, best_vld}, 65'd0);
    @(negedge clk);
    model_push(100, 150, 160, 220);
    chk("R9 vld at third edge", {64'd0, best_vld}, 65'd1);
    chk("R2 delay 110", best_dly, 65'd110);
    chk("R3 offset -5", best_ofs, -65'sd5);
  endtask

  task automatic t_floor();
    exch("R3 odd positive", 0, 10, 10, 13);
    chk("R3 floor of 7/2", best_ofs, 65'd3);
    exch("R3 odd negative", 0, 0, 0, 3);
    chk("R3 floor of -3/2", best_ofs, -65'sd2);
  endtask

  task automatic t_negative();
    exch("R6 negative delay", 0, 100, 200, 50);
    chk("R6 dly unchanged", best_dly, 65'd3);
    chk("R6 ofs unchanged", best_ofs, -65'sd2);
    repeat (3) @(negedge clk);
    chk("R6 still unchanged", best_dly, 65'd3);
  endtask

  task automatic t_tie();
    exch("R7 tie", 1000, 1010, 1010, 1003);
    chk("R7 newer tie wins ofs", best_ofs, 65'd8);
    chk("R7 tie dly", best_dly, 65'd3);
  endtask

  task automatic t_strobes();
    @(negedge clk); a_v = 1; a_t = 2000;
    @(negedge clk); a_v = 0; a_t = 77; b_v = 1; b_t = 2005;
    @(negedge clk); b_v = 0; b_t = 88; c_v = 1; c_t = 2007;
    @(negedge clk); c_v = 0; c_t = 99;
    @(negedge clk); d_v = 1; d_t = 2010;
    @(negedge clk); d_v = 0;
    repeat (3) @(negedge clk);
    model_push(2000, 2005, 2007, 2010);
    chk_model("R1 separate strobes");
    chk("R1 held values dly", best_dly, 65'd8);
    chk("R1 held values ofs", best_ofs, 65'd1);
    @(negedge clk); d_v = 1; d_t = 2008; a_t = -5; b_t = 12345; c_t = 1;
    @(negedge clk); d_v = 0;
    repeat (3) @(negedge clk);
    model_push(2000, 2005, 2007, 2008);
    chk("R1 close-only reuse dly", best_dly, 65'd6);
    chk("R1 close-only reuse ofs", best_ofs, 65'd2);
  endtask

  task automatic t_back_to_back();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      a_v = 1; b_v = 1; c_v = 1; d_v = 1;
      a_t = 3000; b_t = 3000 + k; c_t = 3000 + k; d_t = 3005 - k;
    end
    @(negedge clk);
    idle_inputs();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      model_push(3000, 3000 + k, 3000 + k, 3005 - k);
      chk_model("R9 one per cycle");
    end
    chk("R9 last of burst", best_dly, 65'd3);
  endtask

  task automatic t_evict();
    int dl [8] = '{900, 800, 700, 600, 650, 750, 850, 950};
    for (int k = 0; k < 8; k++)
      exch("R4 fill", 5000, 5000, 5000, 5000 + dl[k]);
    chk("R4 old minimum evicted", best_dly, 65'd600);
    exch("R4 more", 5000, 5000, 5000, 5990);
    exch("R4 more", 5000, 5000, 5000, 5980);
    chk("R5 minimum kept", best_dly, 65'd600);
    for (int k = 0; k < 4; k++)
      exch("R4 push out", 5000, 5000, 5000, 5995);
    chk("R4 oldest replaced", best_dly, 65'd850);
    chk("R5 offset of minimum", best_ofs, -65'sd425);
  endtask

  task automatic t_extremes();
    do_reset();
    chk("R8 invalid after reset", {64'd0, best_vld}, 65'd0);
    exch("R10 max delay", TMIN, TMAX, TMIN, TMAX);
    chk("R10 delay 2^65-2", best_dly, 65'h1_FFFF_FFFF_FFFF_FFFE);
    chk("R10 offset zero", best_ofs, 65'd0);
    exch("R10 max offset", TMIN, TMAX, TMAX, TMIN);
    chk("R10 offset 2^64-1", best_ofs, 65'h0_FFFF_FFFF_FFFF_FFFF);
    exch("R10 min offset", TMAX, TMIN, TMIN, TMAX);
    chk("R10 offset -(2^64-1)", best_ofs, 65'h1_0000_0000_0000_0001);
    chk("R7 zero delay tie", best_dly, 65'd0);
  endtask

  initial begin
    rst = 1'b1;
    idle_inputs();
    a_t = 0; b_t = 0; c_t = 0; d_t = 0;
    model_clear();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_basic_latency();
    t_floor();
    t_negative();
    t_tie();
    do_reset();
    t_strobes();
    t_back_to_back();
    t_evict();
    t_extremes();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule